// File: doc/BRIEF.md
# Trigger Latency Pipeline with Event Buffer

This block sits behind the digitizer of one channel group. One ADC sample arrives on every clock, and the clock runs at six times the beam-crossing rate. Every sample is written into a circular latency line. The line is read back a programmable number of samples later, so the level-1 accept decision can catch up with the data it refers to. That decision arrives 40 crossings, or 240 samples, after the crossing. When an accept arrives, a window of four consecutive delayed samples is copied into a buffer that holds eight events. Each event is tagged with a 16-bit event number. A downstream reader drains the buffer one sample per strobe, oldest event first, so new events can be accepted while older ones are still being read.

In parallel, the block compares each incoming sample against seven programmable thresholds and registers a 3-bit trigger-primitive code. Samples are 12 bits wide, with a baseline near 200 counts.

Triggers that find the buffer full, or that arrive while a window is still being captured, are dropped and counted. Such a trigger still uses up an event number.

Top module: `l1_latency_buffer`

## Requirements
- R1: During cycle t, `latOut` equals the `sampleIn` value driven in cycle t−L, where L is the effective delay, once at least L samples have been written since reset.
- R2: A `latency` value of 0 is used as a delay of 1. Values above 240 are used as 240. Values from 1 to 240 are used as given.
- R3: A trigger accepted in cycle t stores the four samples that `latOut` shows in cycles t to t+3, which are inputs t−L to t−L+3. `evtReady` counts the new event from cycle t+4.
- R4: Event numbers start at 0 after reset and step by one on every `l1Accept` pulse, whether accepted or dropped. A stored event carries the number of the pulse that captured it.
- R5: A buffer slot is reserved in the cycle a trigger is accepted. `busy` is high from the cycle after the eighth slot is reserved. It stays high until the cycle after the last sample of an event is read.
- R6: A trigger that arrives while `busy` is high, or while a capture window is still open, stores nothing. It increments `dropCount` by one, visible in the next cycle.
- R7: `rdValid` is high while at least one complete event is buffered. `rdData` and `rdEvtNum` show the current sample and number of the oldest such event. `rdEn` with `rdValid` advances one sample, and `rdLast` marks the fourth sample. `rdEn` without `rdValid` has no effect.
- R8: In cycle t+1, `primCode` is 0 if `sampleIn` in cycle t lies below every threshold. Otherwise it is 1 plus the highest level index i (0 to 6) with `sampleIn` ≥ threshold i. Level i sits in `thrFlat[12i+11:12i]`.
- R9: After reset, `busy`, `rdValid`, `evtReady`, `dropCount` and `primCode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 12 | ADC sample, one per clock |
| latency | input | 8 | Programmed latency in samples |
| thrFlat | input | 84 | Seven 12-bit thresholds, level i at bits 12i+11:12i |
| l1Accept | input | 1 | Level-1 accept pulse |
| rdEn | input | 1 | Reader takes the presented sample |
| latOut | output | 12 | Delayed sample |
| primCode | output | 3 | Registered trigger-primitive code |
| busy | output | 1 | All eight slots reserved |
| evtReady | output | 4 | Number of complete events buffered |
| dropCount | output | 16 | Number of dropped triggers |
| rdValid | output | 1 | A complete event is presented |
| rdData | output | 12 | Current sample of the head event |
| rdEvtNum | output | 16 | Event number of the head event |
| rdLast | output | 1 | Presented sample is the last of its event |

## Verification
The delayed sample, the read data and the read flags are combinational from registered state, so they are checked in the same cycle their inputs are set. A new event is counted in `evtReady` four cycles after its accept. `busy` and `dropCount` respond one cycle after the trigger, and `busy` falls one cycle after the final read strobe. `primCode` follows its sample by one cycle. The bench drives inputs one time unit after each rising edge and reads outputs at the same point, so every comparison is made at the exact cycle offset listed above. It does not poll for the result.

// File: rtl/l1lb_pkg.sv
package l1lb_pkg;
  localparam int SAMPLE_W = 12;
  localparam int LINE_AW  = 8;
  localparam int MAX_LAT  = 240;
  localparam int WIN      = 4;
  localparam int SLOTS    = 8;
  localparam int LEVELS   = 7;
  localparam int EVT_W    = 16;

  localparam int SLOT_AW  = $clog2(SLOTS);
  localparam int WIN_AW   = $clog2(WIN);
  localparam int CNT_W    = SLOT_AW + 1;
  localparam int CODE_W   = $clog2(LEVELS + 1);
  localparam int THR_W    = LEVELS * SAMPLE_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [LINE_AW-1:0] linePtr;
    logic [LINE_AW-1:0] effLat;
    logic               capWr;
    logic [SLOT_AW-1:0] capSlot;
    logic [WIN_AW-1:0]  capIdx;
    logic               tagWr;
    logic [EVT_W-1:0]   tagVal;
    logic [SLOT_AW-1:0] rdSlot;
    logic [WIN_AW-1:0]  rdIdx;
  } dp_ctrl_t;
endpackage

// File: rtl/l1lb_thr_coder.sv
module l1lb_thr_coder
  import l1lb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [THR_W-1:0]    thrFlat,
  output logic [CODE_W-1:0]   primCode
);
  logic [LEVELS-1:0] hit;
  logic [CODE_W-1:0] codeNext;

  for (genvar i = 0; i < LEVELS; i++) begin : g_cmp
    assign hit[i] = sampleIn >= thrFlat[i*SAMPLE_W +: SAMPLE_W];
  end

  // highest level that fired wins
  always_comb begin
    codeNext = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (hit[i]) codeNext = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primCode <= '0;
    else        primCode <= codeNext;
  end
endmodule

// File: rtl/l1lb_ctrl.sv
module l1lb_ctrl
  import l1lb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               l1Accept,
  input  logic [LINE_AW-1:0] latency,
  input  logic               rdEn,
  output dp_ctrl_t           ctl,
  output logic               busy,
  output logic               rdValid,
  output logic               rdLast,
  output logic [CNT_W-1:0]   evtReady,
  output logic [EVT_W-1:0]   dropCount
);
  logic [LINE_AW-1:0] linePtr;
  logic [LINE_AW-1:0] effLat;
  logic [EVT_W-1:0]   evtNum;
  logic               capActive;
  logic [WIN_AW-1:0]  capCnt;
  logic [SLOT_AW-1:0] wrSlot;
  logic [SLOT_AW-1:0] rdSlot;
  logic [WIN_AW-1:0]  rdIdx;
  logic [CNT_W-1:0]   usedCnt;
  logic [CNT_W-1:0]   readyCnt;

  logic take, drop, capWr, lastWord, popWord, popEvt;
  logic [WIN_AW-1:0] curIdx;

  always_comb begin
    if (latency == '0)                      effLat = LINE_AW'(1);
    else if (latency > LINE_AW'(MAX_LAT))   effLat = LINE_AW'(MAX_LAT);
    else                                    effLat = latency;
  end

  assign busy     = usedCnt == CNT_W'(SLOTS);
  assign take     = l1Accept && !capActive && !busy;
  assign drop     = l1Accept && !take;
  assign curIdx   = capActive ? capCnt : '0;
  assign capWr    = take || capActive;
  assign lastWord = capWr && (curIdx == WIN_AW'(WIN - 1));

  assign rdValid  = readyCnt != '0;
  assign rdLast   = rdIdx == WIN_AW'(WIN - 1);
  assign popWord  = rdEn && rdValid;
  assign popEvt   = popWord && rdLast;
  assign evtReady = readyCnt;

  always_comb begin
    ctl.linePtr = linePtr;
    ctl.effLat  = effLat;
    ctl.capWr   = capWr;
    ctl.capSlot = wrSlot;
    ctl.capIdx  = curIdx;
    ctl.tagWr   = take;
    ctl.tagVal  = evtNum;
    ctl.rdSlot  = rdSlot;
    ctl.rdIdx   = rdIdx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linePtr   <= '0;
      evtNum    <= '0;
      dropCount <= '0;
      capActive <= 1'b0;
      capCnt    <= '0;
      wrSlot    <= '0;
      rdSlot    <= '0;
      rdIdx     <= '0;
      usedCnt   <= '0;
      readyCnt  <= '0;
    end else begin
      linePtr <= linePtr + LINE_AW'(1);
      if (l1Accept) evtNum    <= evtNum + EVT_W'(1);
      if (drop)     dropCount <= dropCount + EVT_W'(1);
      if (capWr) begin
        capCnt    <= curIdx + WIN_AW'(1);
        capActive <= !lastWord;
      end
      if (lastWord) wrSlot <= wrSlot + SLOT_AW'(1);
      usedCnt  <= usedCnt + CNT_W'(take) - CNT_W'(popEvt);
      readyCnt <= readyCnt + CNT_W'(lastWord) - CNT_W'(popEvt);
      if (popWord) rdIdx  <= popEvt ? '0 : rdIdx + WIN_AW'(1);
      if (popEvt)  rdSlot <= rdSlot + SLOT_AW'(1);
    end
  end
endmodule

// File: rtl/l1lb_datapath.sv
module l1lb_datapath
  import l1lb_pkg::*;
(
  input  logic                clk,
  input  dp_ctrl_t            ctl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] latOut,
  output logic [SAMPLE_W-1:0] rdData,
  output logic [EVT_W-1:0]    rdEvtNum
);
  localparam int LINE_DEPTH = 2 ** LINE_AW;

  logic [SAMPLE_W-1:0] lineMem [LINE_DEPTH];
  logic [SAMPLE_W-1:0] evtMem  [SLOTS][WIN];
  logic [EVT_W-1:0]    tagMem  [SLOTS];
  logic [LINE_AW-1:0]  readAddr;

  assign readAddr = ctl.linePtr - ctl.effLat;
  assign latOut   = lineMem[readAddr];
  assign rdData   = evtMem[ctl.rdSlot][ctl.rdIdx];
  assign rdEvtNum = tagMem[ctl.rdSlot];

  always_ff @(posedge clk) begin
    lineMem[ctl.linePtr] <= sampleIn;
    if (ctl.capWr) evtMem[ctl.capSlot][ctl.capIdx] <= latOut;
    if (ctl.tagWr) tagMem[ctl.capSlot] <= ctl.tagVal;
  end
endmodule

// File: rtl/l1_latency_buffer.sv
module l1_latency_buffer
  import l1lb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [LINE_AW-1:0]  latency,
  input  logic [THR_W-1:0]    thrFlat,
  input  logic                l1Accept,
  input  logic                rdEn,
  output logic [SAMPLE_W-1:0] latOut,
  output logic [CODE_W-1:0]   primCode,
  output logic                busy,
  output logic [CNT_W-1:0]    evtReady,
  output logic [EVT_W-1:0]    dropCount,
  output logic                rdValid,
  output logic [SAMPLE_W-1:0] rdData,
  output logic [EVT_W-1:0]    rdEvtNum,
  output logic                rdLast
);
  dp_ctrl_t ctl;

  l1lb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .l1Accept(l1Accept), .latency(latency),
    .rdEn(rdEn), .ctl(ctl), .busy(busy), .rdValid(rdValid),
    .rdLast(rdLast), .evtReady(evtReady), .dropCount(dropCount)
  );

  l1lb_datapath u_dp (
    .clk(clk), .ctl(ctl), .sampleIn(sampleIn), .latOut(latOut),
    .rdData(rdData), .rdEvtNum(rdEvtNum)
  );

  l1lb_thr_coder u_thr (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .thrFlat(thrFlat),
    .primCode(primCode)
  );
endmodule

// File: rtl/l1lb_checker.sv
module l1lb_checker
  import l1lb_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                l1Accept,
  input logic                busy,
  input logic [EVT_W-1:0]    dropCount,
  input logic                rdEn,
  input logic                rdValid,
  input logic                rdLast,
  input logic [EVT_W-1:0]    rdEvtNum,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic [THR_W-1:0]    thrFlat,
  input logic [CODE_W-1:0]   primCode
);
  assert_drop_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l1Accept && busy) |=> dropCount == $past(dropCount) + EVT_W'(1));

  assert_quiet_drop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !l1Accept |=> $stable(dropCount));

  assert_busy_needs_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(l1Accept));

  assert_event_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rdValid && !rdLast) |=> (rdValid && $stable(rdEvtNum)));

  assert_top_level_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleIn >= thrFlat[THR_W-1 -: SAMPLE_W]) |=> primCode == CODE_W'(LEVELS));
endmodule

bind l1_latency_buffer l1lb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .l1Accept(l1Accept), .busy(busy),
  .dropCount(dropCount), .rdEn(rdEn), .rdValid(rdValid), .rdLast(rdLast),
  .rdEvtNum(rdEvtNum), .sampleIn(sampleIn), .thrFlat(thrFlat),
  .primCode(primCode)
);

// File: tb/l1_latency_buffer_tb.sv
module l1_latency_buffer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] sampleIn;
  logic [7:0]  latency;
  logic [83:0] thrFlat;
  logic        l1Accept;
  logic        rdEn;
  logic [11:0] latOut;
  logic [2:0]  primCode;
  logic        busy;
  logic [3:0]  evtReady;
  logic [15:0] dropCount;
  logic        rdValid;
  logic [11:0] rdData;
  logic [15:0] rdEvtNum;
  logic        rdLast;

  logic [11:0] thrV [7];
  int cyc;
  bit ramp;
  logic [11:0] manual;
  int total, fails;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < 7; i++) thrFlat[i*12 +: 12] = thrV[i];

  l1_latency_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .latency(latency),
    .thrFlat(thrFlat), .l1Accept(l1Accept), .rdEn(rdEn), .latOut(latOut),
    .primCode(primCode), .busy(busy), .evtReady(evtReady),
    .dropCount(dropCount), .rdValid(rdValid), .rdData(rdData),
    .rdEvtNum(rdEvtNum), .rdLast(rdLast)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
    sampleIn = ramp ? cyc[11:0] : manual;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int expCode(int v);
    int c = 0;
    for (int i = 0; i < 7; i++) if (v >= int'(thrV[i])) c = i + 1;
    return c;
  endfunction

  // read one whole event captured at cycle k with delay L
  task automatic readEvent(int k, int L, int num, string tag);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " R7 rdValid"}, rdValid, 1);
      chk({tag, " R3 rdData"}, rdData, (k - L + i) & 12'hFFF);
      chk({tag, " R7 rdLast"}, rdLast, (i == 3) ? 1 : 0);
      if (i == 0) chk({tag, " R4 rdEvtNum"}, rdEvtNum, num & 16'hFFFF);
      rdEn = 1'b1;
      tick();
      rdEn = 1'b0;
    end
  endtask

  task automatic trigger();
    l1Accept = 1'b1;
    tick();
    l1Accept = 1'b0;
  endtask

  task automatic testReset();
    chk("R9 busy", busy, 0);
    chk("R9 rdValid", rdValid, 0);
    chk("R9 evtReady", evtReady, 0);
    chk("R9 dropCount", dropCount, 0);
    chk("R9 primCode", primCode, 0);
  endtask

  task automatic testLatency();
    int lats[3] = '{5, 100, 240};
    ticks(300);
    foreach (lats[j]) begin
      latency = 8'(lats[j]);
      #1;
      for (int i = 0; i < 3; i++) begin
        chk("R1 latOut", latOut, (cyc - lats[j]) & 12'hFFF);
        tick();
      end
    end
    latency = 8'd0;
    tick();
    chk("R2 latency 0 acts as 1", latOut, (cyc - 1) & 12'hFFF);
    latency = 8'd250;
    tick();
    chk("R2 latency 250 acts as 240", latOut, (cyc - 240) & 12'hFFF);
  endtask

  task automatic testSingle();
    int k;
    latency = 8'd10;
    tick();
    k = cyc;
    trigger();
    ticks(2);
    chk("R3 not ready at t+3", evtReady, 0);
    tick();
    chk("R3 ready at t+4", evtReady, 1);
    readEvent(k, 10, 0, "single");
    chk("R7 empty after pop", rdValid, 0);
  endtask

  task automatic testOverlap();
    int k1, k2, d0;
    d0 = dropCount;
    k1 = cyc;
    l1Accept = 1'b1;
    tick();
    tick();
    l1Accept = 1'b0;
    chk("R6 drop during capture", dropCount, d0 + 1);
    ticks(4);
    chk("R6 nothing stored for dropped", evtReady, 1);
    k2 = cyc;
    trigger();
    ticks(4);
    readEvent(k1, 10, 1, "overlap1");
    readEvent(k2, 10, 3, "overlap2");
  endtask

  task automatic testFill();
    int ks[8];
    int d0, k;
    latency = 8'd20;
    tick();
    for (int e = 0; e < 8; e++) begin
      if (e == 7) chk("R5 busy low with 7 held", busy, 0);
      ks[e] = cyc;
      trigger();
      if (e == 7) chk("R5 busy after eighth", busy, 1);
      ticks(4);
    end
    d0 = dropCount;
    trigger();
    chk("R6 drop while busy", dropCount, d0 + 1);
    chk("R5 busy holds", busy, 1);
    chk("R5 eight ready", evtReady, 8);
    readEvent(ks[0], 20, 4, "fill0");
    chk("R5 busy clears after free", busy, 0);
    for (int e = 1; e < 8; e++) readEvent(ks[e], 20, 4 + e, "fill");
    chk("R7 drained", rdValid, 0);
    rdEn = 1'b1;
    ticks(3);
    rdEn = 1'b0;
    k = cyc;
    trigger();
    ticks(4);
    readEvent(k, 20, 13, "after idle rdEn");
  endtask

  task automatic testPrim();
    int vals[7] = '{50, 100, 150, 350, 699, 700, 4095};
    ramp = 1'b0;
    foreach (vals[j]) begin
      manual = 12'(vals[j]);
      ticks(2);
      chk("R8 primCode", primCode, expCode(vals[j]));
    end
    thrV[2] = 12'd50;
    manual = 12'd60;
    ticks(2);
    chk("R8 highest level wins", primCode, 3);
    manual = 12'd10;
    ticks(2);
    chk("R8 below all", primCode, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    total = 0; fails = 0; cyc = 0; ramp = 1'b1; manual = '0;
    rst_n = 1'b0; sampleIn = '0; latency = 8'd5;
    l1Accept = 1'b0; rdEn = 1'b0;
    for (int i = 0; i < 7; i++) thrV[i] = 12'((i + 1) * 100);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    testReset();
    testLatency();
    testSingle();
    testOverlap();
    testFill();
    testPrim();
    summary();
    $finish;
  end
endmodule